// File: doc/BRIEF.md
# External Bus Chip-Select Controller

This block sits on the processor side of a shared external parallel bus. An internal requester issues single read or write transfers, each carrying an address, write data and a direction flag. The top bits of the address select one of a few address regions. For a region that is enabled, the controller runs a fixed sequence. It first drives the address for a setup window. It then asserts that region's chip select together with the read or write strobe for an access window. Next it releases everything and reports completion to the requester. One quiet turnaround cycle follows before the next request can be taken.

Each region has its own setup and access counts, loaded from configuration inputs. A region that holds several devices can therefore be stretched to suit its slowest part. The external data bus appears as three signals: an input, an output and an output enable. The controller turns its driver on only while a write strobe is active. An address that hits no enabled region completes at once with an error and touches no chip select.

Top module: `ext_bus_csc`

## Requirements
- R1: The region index is `req_addr[ADDR_W-1 -: RSEL_W]` (the top 3 bits by default). During the access phase, only `bus_cs_n[index]` is low, and every other chip select stays high. Outside the access phase, all chip selects are high.
- R2: All strobes are active low. In the access phase `bus_rd_n` is low for a read (`req_write`=0) and `bus_wr_n` is low for a write (`req_write`=1). Neither strobe is low outside the access phase.
- R3: `bus_addr` takes the request address in the first cycle after acceptance. It holds that value unchanged until the next request is accepted, so it is stable through setup, access, done and turnaround.
- R4: A transfer to region r spends `cfg_setup[4r+3:4r]`+1 cycles in setup, with the address out and no chip select. It then spends `cfg_access[6r+5:6r]`+1 cycles in access. The counts are taken from the configuration at acceptance.
- R5: For a read, the value on `bus_din` in the last access cycle is captured and shown on `rsp_rdata` in the cycle where `rsp_done` is high. `rsp_rdata` is zero for writes, for errors and whenever `rsp_done` is low.
- R6: `bus_doe` is high only during the access phase of a write, and `bus_dout` then carries the request's write data. At all other times `bus_doe` is low.
- R7: `rsp_done` is a one-cycle pulse. For a good transfer it comes in the first cycle after the last access cycle, with all strobes and chip selects already high.
- R8: A request is an error if its index is not below NUM_REGIONS, or if `cfg_en[index]` is 0. An error request gives `rsp_done` and `rsp_err` high in the cycle after acceptance. It asserts no chip select or strobe and never turns on the driver.
- R9: `req_ready` is high only when idle, and a request is accepted at an edge where `req_valid` and `req_ready` are both high. In the cycle after `rsp_done`, `req_ready` stays low and all strobes are inactive. A request held valid through that cycle is accepted at the following edge.
- R10: While `rst_n` is low: `req_ready`=1, all chip selects and strobes are high, `bus_doe`=0, `rsp_done`=0, `rsp_err`=0 and `bus_addr`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_en | input | NUM_REGIONS | Per-region enable |
| cfg_setup | input | NUM_REGIONS*4 | Per-region setup count, 4 bits each |
| cfg_access | input | NUM_REGIONS*6 | Per-region access count, 6 bits each |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle and able to accept |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Transfer address |
| req_wdata | input | DATA_W | Write data |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_err | output | 1 | Completion was an address error |
| rsp_rdata | output | DATA_W | Read data, valid with rsp_done |
| bus_addr | output | ADDR_W | External address bus |
| bus_cs_n | output | NUM_REGIONS | Chip selects, active low, one per region |
| bus_rd_n | output | 1 | Read strobe, active low |
| bus_wr_n | output | 1 | Write strobe, active low |
| bus_dout | output | DATA_W | Data driven toward the bus |
| bus_doe | output | 1 | Output enable for bus_dout |
| bus_din | input | DATA_W | Data received from the bus |

## Verification
The bench feeds `bus_din` a value that changes every cycle. A controller that samples one cycle early or late, or after releasing the chip select, returns the wrong word. Regions are given zero, mid-range and maximum setup and access counts. An off-by-one in either counter, or timing taken from the wrong region, shifts the chip-select window and fails the per-cycle comparison. Requests to a disabled region and to an index beyond the last region must give an immediate error with no chip select; a decoder that ignored the enable bit or wrapped the index would strobe a device. Requests are also held valid back to back. Dropping the turnaround cycle, or driving data during a read, shows up as an early `req_ready` or a stray `bus_doe`.

// File: rtl/ebc_pkg.sv
package ebc_pkg;

    typedef enum logic [2:0] {
        PH_IDLE   = 3'd0,
        PH_SETUP  = 3'd1,
        PH_ACCESS = 3'd2,
        PH_DONE   = 3'd3,
        PH_TURN   = 3'd4
    } ebc_phase_e;

endpackage

// File: rtl/ebc_region_decode.sv
module ebc_region_decode #(
    parameter int NUM_REGIONS = 4,
    parameter int RSEL_W      = 3
) (
    input  logic [RSEL_W-1:0]      idx,
    input  logic [NUM_REGIONS-1:0] en,
    output logic [NUM_REGIONS-1:0] sel,
    output logic                   hit
);

    always_comb begin
        for (int r = 0; r < NUM_REGIONS; r++) begin
            sel[r] = (idx == RSEL_W'(r)) && en[r];
        end
        hit = |sel;
    end

endmodule

// File: rtl/ebc_timing_sel.sv
module ebc_timing_sel #(
    parameter int NUM_REGIONS = 4,
    parameter int SETUP_W     = 4,
    parameter int ACC_W       = 6
) (
    input  logic [NUM_REGIONS-1:0]         sel,
    input  logic [NUM_REGIONS*SETUP_W-1:0] cfg_setup,
    input  logic [NUM_REGIONS*ACC_W-1:0]   cfg_access,
    output logic [SETUP_W-1:0]             setup_cnt,
    output logic [ACC_W-1:0]               access_cnt
);

    logic [SETUP_W-1:0] setup_masked [NUM_REGIONS];
    logic [ACC_W-1:0]   access_masked[NUM_REGIONS];

    for (genvar r = 0; r < NUM_REGIONS; r++) begin : g_region
        assign setup_masked[r]  = sel[r] ? cfg_setup[r*SETUP_W +: SETUP_W] : '0;
        assign access_masked[r] = sel[r] ? cfg_access[r*ACC_W +: ACC_W]    : '0;
    end

    always_comb begin
        setup_cnt  = '0;
        access_cnt = '0;
        for (int r = 0; r < NUM_REGIONS; r++) begin
            setup_cnt  = setup_cnt  | setup_masked[r];
            access_cnt = access_cnt | access_masked[r];
        end
    end

endmodule

// File: rtl/ebc_sequencer.sv
module ebc_sequencer
    import ebc_pkg::*;
#(
    parameter int NUM_REGIONS = 4,
    parameter int ADDR_W      = 16,
    parameter int DATA_W      = 16,
    parameter int SETUP_W     = 4,
    parameter int ACC_W       = 6
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   req_valid,
    input  logic                   req_write,
    input  logic [ADDR_W-1:0]      req_addr,
    input  logic [DATA_W-1:0]      req_wdata,
    input  logic [NUM_REGIONS-1:0] dec_sel,
    input  logic                   dec_hit,
    input  logic [SETUP_W-1:0]     tim_setup,
    input  logic [ACC_W-1:0]       tim_access,
    input  logic [DATA_W-1:0]      bus_din,
    output logic                   req_ready,
    output logic                   rsp_done,
    output logic                   rsp_err,
    output logic [DATA_W-1:0]      rsp_rdata,
    output logic [ADDR_W-1:0]      bus_addr,
    output logic [NUM_REGIONS-1:0] bus_cs_n,
    output logic                   bus_rd_n,
    output logic                   bus_wr_n,
    output logic [DATA_W-1:0]      bus_dout,
    output logic                   bus_doe
);

    typedef struct packed {
        ebc_phase_e             ph;
        logic [ADDR_W-1:0]      addr;
        logic [DATA_W-1:0]      wdata;
        logic [DATA_W-1:0]      rdata;
        logic                   wr;
        logic                   err;
        logic [NUM_REGIONS-1:0] sel;
        logic [SETUP_W-1:0]     scnt;
        logic [ACC_W-1:0]       acnt;
    } seq_t;

    seq_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        unique case (st_q.ph)
            PH_IDLE: begin
                if (req_valid) begin
                    st_d.addr  = req_addr;
                    st_d.wdata = req_wdata;
                    st_d.wr    = req_write;
                    st_d.rdata = '0;
                    st_d.sel   = dec_sel;
                    st_d.scnt  = tim_setup;
                    st_d.acnt  = tim_access;
                    st_d.err   = !dec_hit;
                    st_d.ph    = dec_hit ? PH_SETUP : PH_DONE;
                end
            end
            PH_SETUP: begin
                if (st_q.scnt == '0) begin
                    st_d.ph = PH_ACCESS;
                end else begin
                    st_d.scnt = st_q.scnt - 1'b1;
                end
            end
            PH_ACCESS: begin
                if (st_q.acnt == '0) begin
                    if (!st_q.wr) begin
                        st_d.rdata = bus_din;
                    end
                    st_d.ph = PH_DONE;
                end else begin
                    st_d.acnt = st_q.acnt - 1'b1;
                end
            end
            PH_DONE: begin
                st_d.ph = PH_TURN;
            end
            PH_TURN: begin
                st_d.err = 1'b0;
                st_d.ph  = PH_IDLE;
            end
            default: begin
                st_d.ph = PH_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    logic in_access;
    assign in_access = (st_q.ph == PH_ACCESS);

    assign req_ready = (st_q.ph == PH_IDLE);
    assign rsp_done  = (st_q.ph == PH_DONE);
    assign rsp_err   = rsp_done && st_q.err;
    assign rsp_rdata = rsp_done ? st_q.rdata : '0;
    assign bus_addr  = st_q.addr;
    assign bus_cs_n  = in_access ? ~st_q.sel : '1;
    assign bus_rd_n  = !(in_access && !st_q.wr);
    assign bus_wr_n  = !(in_access && st_q.wr);
    assign bus_doe   = in_access && st_q.wr;
    assign bus_dout  = bus_doe ? st_q.wdata : '0;

endmodule

// File: rtl/ext_bus_csc.sv
module ext_bus_csc #(
    parameter int NUM_REGIONS = 4,
    parameter int RSEL_W      = 3,
    parameter int ADDR_W      = 16,
    parameter int DATA_W      = 16,
    parameter int SETUP_W     = 4,
    parameter int ACC_W       = 6
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [NUM_REGIONS-1:0]         cfg_en,
    input  logic [NUM_REGIONS*SETUP_W-1:0] cfg_setup,
    input  logic [NUM_REGIONS*ACC_W-1:0]   cfg_access,
    input  logic                           req_valid,
    output logic                           req_ready,
    input  logic                           req_write,
    input  logic [ADDR_W-1:0]              req_addr,
    input  logic [DATA_W-1:0]              req_wdata,
    output logic                           rsp_done,
    output logic                           rsp_err,
    output logic [DATA_W-1:0]              rsp_rdata,
    output logic [ADDR_W-1:0]              bus_addr,
    output logic [NUM_REGIONS-1:0]         bus_cs_n,
    output logic                           bus_rd_n,
    output logic                           bus_wr_n,
    output logic [DATA_W-1:0]              bus_dout,
    output logic                           bus_doe,
    input  logic [DATA_W-1:0]              bus_din
);

    localparam int IDX_LSB = ADDR_W - RSEL_W;

    logic [RSEL_W-1:0]      region_idx;
    logic [NUM_REGIONS-1:0] region_sel;
    logic                   region_hit;
    logic [SETUP_W-1:0]     setup_cnt;
    logic [ACC_W-1:0]       access_cnt;

    assign region_idx = req_addr[ADDR_W-1:IDX_LSB];

    ebc_region_decode #(
        .NUM_REGIONS (NUM_REGIONS),
        .RSEL_W      (RSEL_W)
    ) u_decode (
        .idx (region_idx),
        .en  (cfg_en),
        .sel (region_sel),
        .hit (region_hit)
    );

    ebc_timing_sel #(
        .NUM_REGIONS (NUM_REGIONS),
        .SETUP_W     (SETUP_W),
        .ACC_W       (ACC_W)
    ) u_timing (
        .sel        (region_sel),
        .cfg_setup  (cfg_setup),
        .cfg_access (cfg_access),
        .setup_cnt  (setup_cnt),
        .access_cnt (access_cnt)
    );

    ebc_sequencer #(
        .NUM_REGIONS (NUM_REGIONS),
        .ADDR_W      (ADDR_W),
        .DATA_W      (DATA_W),
        .SETUP_W     (SETUP_W),
        .ACC_W       (ACC_W)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_write  (req_write),
        .req_addr   (req_addr),
        .req_wdata  (req_wdata),
        .dec_sel    (region_sel),
        .dec_hit    (region_hit),
        .tim_setup  (setup_cnt),
        .tim_access (access_cnt),
        .bus_din    (bus_din),
        .req_ready  (req_ready),
        .rsp_done   (rsp_done),
        .rsp_err    (rsp_err),
        .rsp_rdata  (rsp_rdata),
        .bus_addr   (bus_addr),
        .bus_cs_n   (bus_cs_n),
        .bus_rd_n   (bus_rd_n),
        .bus_wr_n   (bus_wr_n),
        .bus_dout   (bus_dout),
        .bus_doe    (bus_doe)
    );

endmodule

// File: rtl/ext_bus_csc_chk.sv
module ext_bus_csc_chk #(
    parameter int NUM_REGIONS = 4,
    parameter int ADDR_W      = 16,
    parameter int DATA_W      = 16
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   req_ready,
    input logic                   rsp_done,
    input logic                   rsp_err,
    input logic [DATA_W-1:0]      rsp_rdata,
    input logic [ADDR_W-1:0]      bus_addr,
    input logic [NUM_REGIONS-1:0] bus_cs_n,
    input logic                   bus_rd_n,
    input logic                   bus_wr_n,
    input logic                   bus_doe
);

    a_r1_cs_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~bus_cs_n));

    a_r2_one_strobe_with_cs: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_cs_n != '1) |-> (bus_rd_n != bus_wr_n));

    a_r2_no_strobe_without_cs: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_cs_n == '1) |-> (bus_rd_n && bus_wr_n));

    a_r3_addr_setup_before_cs: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(bus_cs_n) == '1) && (bus_cs_n != '1)) |-> $stable(bus_addr));

    a_r3_addr_held_during_cs: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(bus_cs_n) != '1) && (bus_cs_n != '1)) |-> $stable(bus_addr));

    a_r5_rdata_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_done |-> (rsp_rdata == '0));

    a_r6_drive_only_on_write: assert property (@(posedge clk) disable iff (!rst_n)
        bus_doe |-> (!bus_wr_n && bus_rd_n));

    a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> !rsp_done);

    a_r7_done_after_release: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_done && !rsp_err) |-> ((bus_cs_n == '1) && ($past(bus_cs_n) != '1)));

    a_r8_err_immediate: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> (rsp_done && $past(req_ready) && (bus_cs_n == '1)));

    a_r9_turnaround: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> (!req_ready && (bus_cs_n == '1) && bus_rd_n && bus_wr_n));

endmodule

bind ext_bus_csc ext_bus_csc_chk #(
    .NUM_REGIONS (NUM_REGIONS),
    .ADDR_W      (ADDR_W),
    .DATA_W      (DATA_W)
) u_chk (.*);

// File: tb/ext_bus_csc_tb.sv
module ext_bus_csc_tb;

    localparam int NR = 4;
    localparam int AW = 16;
    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NR-1:0] cfg_en = '0;
    logic [NR*4-1:0] cfg_setup = '0;
    logic [NR*6-1:0] cfg_access = '0;
    logic          req_valid = 1'b0;
    logic          req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic [DW-1:0] bus_din = '0;
    logic          req_ready, rsp_done, rsp_err, bus_rd_n, bus_wr_n, bus_doe;
    logic [DW-1:0] rsp_rdata, bus_dout;
    logic [AW-1:0] bus_addr;
    logic [NR-1:0] bus_cs_n;

    always #2.5 clk = ~clk;

    ext_bus_csc u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_setup(cfg_setup),
        .cfg_access(cfg_access), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_done(rsp_done), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
        .bus_addr(bus_addr), .bus_cs_n(bus_cs_n), .bus_rd_n(bus_rd_n),
        .bus_wr_n(bus_wr_n), .bus_dout(bus_dout), .bus_doe(bus_doe),
        .bus_din(bus_din)
    );

    typedef struct {
        logic [NR-1:0] cs_n;
        logic          rd_n;
        logic          wr_n;
        logic          doe;
        logic [DW-1:0] dout;
        logic          done;
        logic          err;
        logic          ready;
        logic          cap;
        logic          use_cap;
    } exp_t;

    exp_t   exp_q[$];
    int     n_cmp = 0;
    int     n_bad = 0;
    int     cyc = 0;
    logic   model_ready = 1'b1;
    logic [AW-1:0] m_addr = '0;
    logic [DW-1:0] cap_val = '0;

    function automatic exp_t quiet(input logic rdy);
        exp_t e;
        e.cs_n = '1; e.rd_n = 1'b1; e.wr_n = 1'b1; e.doe = 1'b0; e.dout = '0;
        e.done = 1'b0; e.err = 1'b0; e.ready = rdy; e.cap = 1'b0; e.use_cap = 1'b0;
        return e;
    endfunction

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] expv);
        n_cmp++;
        if (got !== expv) begin
            n_bad++;
            $display("FAIL %s cycle %0d: got %h expected %h", tag, cyc, got, expv);
        end
    endtask

    // Reference model: on acceptance, lay out the expected outputs of every following cycle.
    always @(posedge clk) begin
        if (rst_n && model_ready && req_valid) begin
            int   idx;
            exp_t e;
            idx = int'(req_addr[AW-1 -: 3]);
            m_addr = req_addr;
            if (idx >= NR || !cfg_en[idx]) begin
                e = quiet(1'b0); e.done = 1'b1; e.err = 1'b1;
                exp_q.push_back(e);
            end else begin
                int s, a;
                s = int'(cfg_setup[idx*4 +: 4]);
                a = int'(cfg_access[idx*6 +: 6]);
                for (int i = 0; i <= s; i++) exp_q.push_back(quiet(1'b0));
                for (int i = 0; i <= a; i++) begin
                    e = quiet(1'b0);
                    e.cs_n = ~(NR'(1) << idx);
                    e.rd_n = req_write;
                    e.wr_n = !req_write;
                    e.doe  = req_write;
                    e.dout = req_write ? req_wdata : '0;
                    e.cap  = (i == a) && !req_write;
                    exp_q.push_back(e);
                end
                e = quiet(1'b0); e.done = 1'b1; e.use_cap = !req_write;
                exp_q.push_back(e);
            end
            exp_q.push_back(quiet(1'b0));
        end
    end

    always @(negedge clk) begin
        exp_t e;
        logic [DW-1:0] er;
        cyc++;
        if (!rst_n) begin
            exp_q.delete();
            m_addr = '0;
            e = quiet(1'b1);
        end else begin
            e = (exp_q.size() > 0) ? exp_q.pop_front() : quiet(1'b1);
        end
        er = e.use_cap ? cap_val : '0;
        if (!rst_n) begin
            chk("R10 ready", 32'(req_ready), 32'(1'b1));
            chk("R10 cs_n", 32'(bus_cs_n), 32'(e.cs_n));
            chk("R10 strobes", 32'({bus_rd_n, bus_wr_n}), 32'(2'b11));
            chk("R10 doe/done/err", 32'({bus_doe, rsp_done, rsp_err}), 32'(3'b000));
            chk("R10 addr", 32'(bus_addr), 32'(0));
        end else begin
            chk("R1 R4 cs_n", 32'(bus_cs_n), 32'(e.cs_n));
            chk("R2 rd_n", 32'(bus_rd_n), 32'(e.rd_n));
            chk("R2 wr_n", 32'(bus_wr_n), 32'(e.wr_n));
            chk("R3 addr", 32'(bus_addr), 32'(m_addr));
            chk("R6 doe", 32'(bus_doe), 32'(e.doe));
            if (e.doe) chk("R6 dout", 32'(bus_dout), 32'(e.dout));
            chk("R7 done", 32'(rsp_done), 32'(e.done));
            chk("R8 err", 32'(rsp_err), 32'(e.err));
            chk("R9 ready", 32'(req_ready), 32'(e.ready));
            chk("R5 rdata", 32'(rsp_rdata), 32'(er));
        end
        model_ready = rst_n ? e.ready : 1'b1;
        bus_din = DW'(cyc * 37 + 5);
        if (e.cap) cap_val = bus_din;
    end

    task automatic issue(input logic w, input logic [AW-1:0] a, input logic [DW-1:0] wd);
        @(negedge clk);
        req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = wd;
        do @(posedge clk); while (!model_ready);
    endtask

    task automatic release_req();
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: run did not end, got hang expected finish");
        finish_run();
    end

    initial begin
        cfg_en     = 4'b0111;
        cfg_setup  = {4'd1, 4'd5, 4'd2, 4'd0};
        cfg_access = {6'd2, 6'd1, 6'd3, 6'd0};
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        issue(1'b1, 16'h0012, 16'hA5A5);   // R6 write, region 0, shortest timing
        issue(1'b0, 16'h0034, 16'h0000);   // R5 read, region 0
        issue(1'b0, 16'h2100, 16'h0000);   // R4 read, region 1
        issue(1'b1, 16'h4ABC, 16'h1234);   // R2 write, region 2
        issue(1'b0, 16'h6001, 16'h0000);   // R8 disabled region 3
        issue(1'b1, 16'hA000, 16'hFFFF);   // R8 index beyond last region
        issue(1'b0, 16'h5555, 16'h0000);   // R9 held valid across turnaround
        release_req();
        repeat (3) @(negedge clk);
        cfg_en     = 4'b1111;
        cfg_setup  = {4'd1, 4'd5, 4'd15, 4'd0};
        cfg_access = {6'd2, 6'd1, 6'd63, 6'd0};
        issue(1'b0, 16'h3FFE, 16'h0000);   // R4 maximum counts
        issue(1'b1, 16'h7777, 16'h0F0F);   // R1 region 3 now enabled
        issue(1'b0, 16'h6123, 16'h0000);
        release_req();
        repeat (6) @(negedge clk);
        finish_run();
    end

endmodule